// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Scanner

This block drives a passive liquid-crystal panel of up to four commons and twenty segments by time multiplexing. A small display store holds one 4-bit nibble per segment, and bit n of a nibble lights the pixel where that segment crosses common n. Each output pin carries a 2-bit level code, which an external resistor ladder and buffers turn into one of four voltages. Code 0 is ground, 1 is VLC1, 2 is VLC2 and 3 is VLC3.

A host writes the display store and two 4-bit configuration registers through a simple write port. The write column `wr_col` is 0 to 2 for the store and 3 for the configuration registers. The first configuration register (address 0) holds three fields: bit 3 picks the low-resistance ladder, bit 2 enables the display, and bits 1:0 set duty and bias. The second register (address 1) has bits 3, 2 and 1, which turn SEG0, SEG1 and SEG2 into supply pins, and bit 0, which switches the internal ladder off. A slow tick input, divided by a programmable prescaler, steps the scan from one common phase to the next. The drive polarity inverts on every frame.

Top module: `lcd_mux_drv`

## Requirements
- R1: After reset, the first configuration register is 0000 (display off) and the second is 1111. Every common and every scanned segment is at code 3. SEG0, SEG1 and SEG2 show supply codes 3, 2 and 1, `sup_pin` is 111, `ladder_off` is 1 and `ladder_lo_r` is 0.
- R2: Store writes use `wr_col` c (0 to 2) and `wr_addr` a (8 to 15) and land in segment c*8+(a-8). Nibble bit n belongs to common n. Writes with an address below 8, or to segments 20 and above (column 2, addresses 12 to 15), change no output.
- R3: Duty/bias field 01 gives 2 phases at 1/2 bias, 10 gives 3 phases at 1/3 bias, and 11 gives 4 phases at 1/3 bias. Phase k selects common k. Commons at or beyond the phase count stay at the non-select level.
- R4: A selected common drives code 3 in even frames and code 0 in odd frames. A lit segment drives the opposite extreme, so a lit pixel sees the full VLC3 difference.
- R5: At 1/3 bias, non-selected commons drive 1 (even frame) or 2 (odd frame), and unlit segments drive 2 (even) or 1 (odd). At 1/2 bias, non-selected commons drive 1, and unlit segments drive the same level as the selected common.
- R6: The frame polarity inverts each time the scan wraps from the last phase back to phase 0.
- R7: While `bkup` is high, the display enable is 0, or the duty field is 00, every common and every scanned segment is at code 3. The scan restarts at phase 0 in an even frame when blanking ends.
- R8: Configuration registers and store contents are kept through back-up mode. Only a write changes them.
- R9: When its reassign bit is set, SEG0 carries code 3, SEG1 code 2 and SEG2 code 1 (`sup_pin` bits 0, 1 and 2), and the scan never drives that pin. With the bit clear, the pin is scanned like any other segment.
- R10: The scan advances by one phase every `phase_div`+1 pulses of `slow_tick`.
- R11: `ladder_lo_r` follows bit 3 of the first configuration register, and `ladder_off` follows bit 0 of the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bkup | input | 1 | Back-up mode, blanks the panel |
| wr_en | input | 1 | Write strobe |
| wr_col | input | 2 | Store column 0-2, or 3 for configuration |
| wr_addr | input | 4 | Row address within column |
| wr_data | input | 4 | Write data nibble |
| slow_tick | input | 1 | Slow timebase pulse, one clock wide |
| phase_div | input | 8 | Prescaler terminal count |
| com_lv | output | 8 | Level code per common, 2 bits each |
| seg_lv | output | 40 | Level code per segment, 2 bits each |
| sup_pin | output | 3 | SEG0..SEG2 currently act as supply pins |
| ladder_lo_r | output | 1 | Low-resistance ladder select |
| ladder_off | output | 1 | Internal ladder disabled |

## Verification
A bad phase counter appears at the next output register update as the wrong common at a select level, or as two commons at select levels at once. A phase count that ignores the duty setting shows up within one frame, because a common beyond the duty count gets selected. A frame-polarity flop stuck at one value shows within one full frame of ticks, because the selected common never moves to the opposite extreme. Mapping or blanking faults show one clock after the write or `bkup` change that exposes them, as a pin code that differs from the model.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    typedef enum logic [1:0] {
        LV_GND  = 2'd0,
        LV_VLC1 = 2'd1,
        LV_VLC2 = 2'd2,
        LV_VLC3 = 2'd3
    } lv_e;

    // first configuration register
    typedef struct packed {
        logic       lo_r;
        logic       en;
        logic [1:0] duty;
    } cfg_a_t;

    // second configuration register
    typedef struct packed {
        logic seg0_sup;
        logic seg1_sup;
        logic seg2_sup;
        logic ladder_off;
    } cfg_b_t;

    typedef struct packed {
        logic       blank;
        logic       half;
        logic [2:0] nphase;
    } mode_t;

    localparam int NSUP = 3;

    function automatic logic [2:0] duty_phases(input logic [1:0] duty);
        case (duty)
            2'b01:   return 3'd2;
            2'b10:   return 3'd3;
            2'b11:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic lv_e com_level(input logic sel, input logic pol, input logic half);
        if (sel)
            return pol ? LV_GND : LV_VLC3;
        else if (half)
            return LV_VLC1;
        else
            return pol ? LV_VLC2 : LV_VLC1;
    endfunction

    function automatic lv_e seg_level(input logic on, input logic pol, input logic half);
        if (on)
            return pol ? LV_VLC3 : LV_GND;
        else if (half)
            return pol ? LV_GND : LV_VLC3;
        else
            return pol ? LV_VLC1 : LV_VLC2;
    endfunction

    function automatic lv_e sup_level(input int k);
        case (k)
            0:       return LV_VLC3;
            1:       return LV_VLC2;
            default: return LV_VLC1;
        endcase
    endfunction

endpackage

// File: rtl/lcd_regs.sv
module lcd_regs
    import lcd_pkg::*;
#(
    parameter int NSEG     = 20,
    parameter int NCOM     = 4,
    parameter int COL_SEGS = 8,
    parameter int RAM_BASE = 8,
    parameter int COL_W    = 2,
    parameter int ADDR_W   = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [COL_W-1:0]       wr_col,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [NCOM-1:0]        wr_data,
    output cfg_a_t                 cfg_a,
    output cfg_b_t                 cfg_b,
    output logic [NSEG*NCOM-1:0]   pix
);
    localparam logic [COL_W-1:0] CTL_COL = '1;

    logic ctl_hit;
    assign ctl_hit = wr_en && (wr_col == CTL_COL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a <= '0;
            cfg_b <= '1;
        end else if (ctl_hit) begin
            if (wr_addr == ADDR_W'(0)) cfg_a <= cfg_a_t'(wr_data[3:0]);
            if (wr_addr == ADDR_W'(1)) cfg_b <= cfg_b_t'(wr_data[3:0]);
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_cell
        localparam int COL = s / COL_SEGS;
        localparam int ROW = (s % COL_SEGS) + RAM_BASE;
        logic hit;
        assign hit = wr_en && (wr_col == COL_W'(COL)) && (wr_addr == ADDR_W'(ROW));
        always_ff @(posedge clk) begin
            if (rst)
                pix[s*NCOM +: NCOM] <= '0;
            else if (hit)
                pix[s*NCOM +: NCOM] <= wr_data;
        end
    end

endmodule

// File: rtl/lcd_scan.sv
module lcd_scan
    import lcd_pkg::*;
#(
    parameter int NCOM  = 4,
    parameter int PRE_W = 8,
    localparam int PH_W = (NCOM > 1) ? $clog2(NCOM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode,
    input  logic             tick,
    input  logic [PRE_W-1:0] div,
    output logic [PH_W-1:0]  phase,
    output logic             pol
);
    logic [PRE_W-1:0] cnt;
    logic [PH_W-1:0]  last_ph;

    assign last_ph = PH_W'(mode.nphase - 3'd1);

    always_ff @(posedge clk) begin
        if (rst || mode.blank) begin
            cnt   <= '0;
            phase <= '0;
            pol   <= 1'b0;
        end else if (phase > last_ph) begin
            phase <= '0;
        end else if (tick) begin
            if (cnt >= div) begin
                cnt <= '0;
                if (phase == last_ph) begin
                    phase <= '0;
                    pol   <= ~pol;
                end else begin
                    phase <= phase + PH_W'(1);
                end
            end else begin
                cnt <= cnt + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/lcd_level.sv
module lcd_level
    import lcd_pkg::*;
#(
    parameter int NSEG = 20,
    parameter int NCOM = 4,
    localparam int PH_W = (NCOM > 1) ? $clog2(NCOM) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mode_t                mode,
    input  logic [PH_W-1:0]      phase,
    input  logic                 pol,
    input  logic [NSEG*NCOM-1:0] pix,
    input  cfg_b_t               cfg_b,
    output logic [2*NCOM-1:0]    com_lv,
    output logic [2*NSEG-1:0]    seg_lv,
    output logic [NSUP-1:0]      sup_pin
);
    logic [NSUP-1:0] sup_req;
    assign sup_req = {cfg_b.seg2_sup, cfg_b.seg1_sup, cfg_b.seg0_sup};

    always_ff @(posedge clk) begin
        if (rst) sup_pin <= '1;
        else     sup_pin <= sup_req;
    end

    for (genvar c = 0; c < NCOM; c++) begin : g_com
        lv_e nxt;
        assign nxt = mode.blank ? LV_VLC3
                   : com_level(phase == PH_W'(c), pol, mode.half);
        always_ff @(posedge clk) begin
            if (rst) com_lv[2*c +: 2] <= LV_VLC3;
            else     com_lv[2*c +: 2] <= nxt;
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [NCOM-1:0] bits;
        lv_e             scan_lv;
        lv_e             nxt;
        assign bits    = pix[s*NCOM +: NCOM];
        assign scan_lv = mode.blank ? LV_VLC3 : seg_level(bits[phase], pol, mode.half);
        if (s < NSUP) begin : g_sup
            assign nxt = sup_req[s] ? sup_level(s) : scan_lv;
            always_ff @(posedge clk) begin
                if (rst) seg_lv[2*s +: 2] <= sup_level(s);
                else     seg_lv[2*s +: 2] <= nxt;
            end
        end else begin : g_plain
            assign nxt = scan_lv;
            always_ff @(posedge clk) begin
                if (rst) seg_lv[2*s +: 2] <= LV_VLC3;
                else     seg_lv[2*s +: 2] <= nxt;
            end
        end
    end

endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
    import lcd_pkg::*;
#(
    parameter int NSEG     = 20,
    parameter int NCOM     = 4,
    parameter int COL_SEGS = 8,
    parameter int RAM_BASE = 8,
    parameter int PRE_W    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bkup,
    input  logic               wr_en,
    input  logic [1:0]         wr_col,
    input  logic [3:0]         wr_addr,
    input  logic [3:0]         wr_data,
    input  logic               slow_tick,
    input  logic [PRE_W-1:0]   phase_div,
    output logic [2*NCOM-1:0]  com_lv,
    output logic [2*NSEG-1:0]  seg_lv,
    output logic [2:0]         sup_pin,
    output logic               ladder_lo_r,
    output logic               ladder_off
);
    localparam int PH_W = (NCOM > 1) ? $clog2(NCOM) : 1;

    cfg_a_t                cfg_a;
    cfg_b_t                cfg_b;
    logic [NSEG*NCOM-1:0]  pix;
    mode_t                 mode;
    logic [PH_W-1:0]       phase;
    logic                  pol;

    always_comb begin
        mode.nphase = duty_phases(cfg_a.duty);
        mode.half   = (cfg_a.duty == 2'b01);
        mode.blank  = bkup || !cfg_a.en || (cfg_a.duty == 2'b00);
    end

    assign ladder_lo_r = cfg_a.lo_r;
    assign ladder_off  = cfg_b.ladder_off;

    lcd_regs #(
        .NSEG(NSEG), .NCOM(NCOM), .COL_SEGS(COL_SEGS),
        .RAM_BASE(RAM_BASE), .COL_W(2), .ADDR_W(4)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_col(wr_col),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .pix(pix)
    );

    lcd_scan #(.NCOM(NCOM), .PRE_W(PRE_W)) u_scan (
        .clk(clk), .rst(rst), .mode(mode), .tick(slow_tick),
        .div(phase_div), .phase(phase), .pol(pol)
    );

    lcd_level #(.NSEG(NSEG), .NCOM(NCOM)) u_level (
        .clk(clk), .rst(rst), .mode(mode), .phase(phase), .pol(pol),
        .pix(pix), .cfg_b(cfg_b),
        .com_lv(com_lv), .seg_lv(seg_lv), .sup_pin(sup_pin)
    );

endmodule

// File: rtl/lcd_mux_chk.sv
module lcd_mux_chk #(
    parameter int NSEG = 20,
    parameter int NCOM = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bkup,
    input logic              wr_en,
    input logic [2*NCOM-1:0] com_lv,
    input logic [2*NSEG-1:0] seg_lv,
    input logic [2:0]        sup_pin,
    input logic              ladder_lo_r,
    input logic              ladder_off
);
    logic [NCOM-1:0] at_ext;
    logic [NCOM-1:0] at_mid;
    logic            scanned_top;

    always_comb begin
        for (int i = 0; i < NCOM; i++) begin
            at_ext[i] = (com_lv[2*i +: 2] == 2'd0) || (com_lv[2*i +: 2] == 2'd3);
            at_mid[i] = !at_ext[i];
        end
        scanned_top = 1'b1;
        for (int j = 3; j < NSEG; j++)
            if (seg_lv[2*j +: 2] != 2'd3) scanned_top = 1'b0;
    end

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (&com_lv) && scanned_top && (sup_pin == 3'b111) && ladder_off && !ladder_lo_r);

    // R7
    bkup_blank_chk: assert property (@(posedge clk) disable iff (rst)
        bkup |=> (&com_lv) && scanned_top);

    // R3
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        (|at_mid) |-> ($countones(at_ext) == 1));

    // R9
    sup_seg0_chk: assert property (@(posedge clk) disable iff (rst)
        sup_pin[0] |-> (seg_lv[1:0] == 2'd3));
    // R9
    sup_seg1_chk: assert property (@(posedge clk) disable iff (rst)
        sup_pin[1] |-> (seg_lv[3:2] == 2'd2));
    // R9
    sup_seg2_chk: assert property (@(posedge clk) disable iff (rst)
        sup_pin[2] |-> (seg_lv[5:4] == 2'd1));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({ladder_lo_r, ladder_off}));

endmodule

bind lcd_mux_drv lcd_mux_chk #(.NSEG(NSEG), .NCOM(NCOM)) u_chk (
    .clk(clk), .rst(rst), .bkup(bkup), .wr_en(wr_en),
    .com_lv(com_lv), .seg_lv(seg_lv), .sup_pin(sup_pin),
    .ladder_lo_r(ladder_lo_r), .ladder_off(ladder_off)
);

// File: tb/sim_lcd_mux_drv.sv
`timescale 1ns/1ps
module sim_lcd_mux_drv;
    localparam int NSEG = 20;
    localparam int NCOM = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bkup = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_col = '0;
    logic [3:0]  wr_addr = '0;
    logic [3:0]  wr_data = '0;
    logic        slow_tick = 1'b0;
    logic [7:0]  phase_div = '0;
    logic [2*NCOM-1:0] com_lv;
    logic [2*NSEG-1:0] seg_lv;
    logic [2:0]  sup_pin;
    logic        ladder_lo_r;
    logic        ladder_off;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of programmed state
    logic [3:0] bram [NSEG];
    logic [3:0] ba = 4'b0000;
    logic [3:0] bb = 4'b1111;
    int ph = 0;
    int pol = 0;
    int bcnt = 0;

    always #5 clk = ~clk;

    lcd_mux_drv u0 (
        .clk(clk), .rst(rst), .bkup(bkup), .wr_en(wr_en), .wr_col(wr_col),
        .wr_addr(wr_addr), .wr_data(wr_data), .slow_tick(slow_tick),
        .phase_div(phase_div), .com_lv(com_lv), .seg_lv(seg_lv),
        .sup_pin(sup_pin), .ladder_lo_r(ladder_lo_r), .ladder_off(ladder_off)
    );

    function automatic bit m_blank();
        return bkup || !ba[2] || (ba[1:0] == 2'b00);
    endfunction

    function automatic int m_nph();
        return (ba[1:0] == 2'b01) ? 2 : (ba[1:0] == 2'b10) ? 3 : 4;
    endfunction

    function automatic logic [1:0] m_com(int i);
        if (m_blank()) return 2'd3;
        if (i == ph) return (pol != 0) ? 2'd0 : 2'd3;
        if (ba[1:0] == 2'b01) return 2'd1;
        return (pol != 0) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [1:0] m_seg(int j);
        logic on;
        if (j == 0 && bb[3]) return 2'd3;
        if (j == 1 && bb[2]) return 2'd2;
        if (j == 2 && bb[1]) return 2'd1;
        if (m_blank()) return 2'd3;
        on = bram[j][ph];
        if (on) return (pol != 0) ? 2'd3 : 2'd0;
        if (ba[1:0] == 2'b01) return (pol != 0) ? 2'd0 : 2'd3;
        return (pol != 0) ? 2'd1 : 2'd2;
    endfunction

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_pins(string tag);
        logic [2*NCOM-1:0] ec;
        logic [2*NSEG-1:0] es;
        logic [2:0] esup;
        for (int i = 0; i < NCOM; i++) ec[2*i +: 2] = m_com(i);
        for (int j = 0; j < NSEG; j++) es[2*j +: 2] = m_seg(j);
        esup = {bb[1], bb[2], bb[3]};
        check({tag, " com"}, 64'(com_lv), 64'(ec));
        check({tag, " seg"}, 64'(seg_lv), 64'(es));
        check({tag, " sup"}, 64'(sup_pin), 64'(esup));
    endtask

    task automatic wr(input logic [1:0] c, input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_col = c; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (c == 2'd3) begin
            if (a == 4'd0) ba = d;
            if (a == 4'd1) bb = d;
        end else if (a >= 4'd8) begin
            int s;
            s = int'(c) * 8 + int'(a) - 8;
            if (s < NSEG) bram[s] = d;
        end
        if (m_blank()) begin ph = 0; pol = 0; bcnt = 0; end
        settle();
    endtask

    task automatic tick();
        @(negedge clk);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        if (!m_blank()) begin
            if (bcnt >= int'(phase_div)) begin
                bcnt = 0;
                if (ph == m_nph() - 1) begin ph = 0; pol ^= 1; end
                else ph++;
            end else bcnt++;
        end
        settle();
    endtask

    // R1
    task automatic t_reset();
        check_pins("R1 reset");
        check("R1 ladder_off", 64'(ladder_off), 64'd1);
        check("R1 ladder_lo_r", 64'(ladder_lo_r), 64'd0);
        check("R1 seg0-2 supply codes", 64'(seg_lv[5:0]), 64'b01_10_11);
    endtask

    // R2 R3 R4 R5 R6 R9 R11
    task automatic t_scan4();
        wr(2'd3, 4'd1, 4'b0000);
        check("R11 ladder_off cleared", 64'(ladder_off), 64'd0);
        check_pins("R9 supply released, blank");
        wr(2'd0, 4'd8,  4'b0001);
        wr(2'd0, 4'd15, 4'b1000);
        wr(2'd1, 4'd8,  4'b0010);
        wr(2'd1, 4'd15, 4'b0100);
        wr(2'd2, 4'd8,  4'b1111);
        wr(2'd2, 4'd11, 4'b0101);
        wr(2'd0, 4'd9,  4'b1010);
        wr(2'd0, 4'd0,  4'b0111);
        wr(2'd3, 4'd0,  4'b0111);
        check_pins("R2 R3 R4 R5 duty4 phase0");
        for (int k = 0; k < 8; k++) begin
            tick();
            check_pins($sformatf("R3 R4 R5 R6 duty4 step%0d", k));
        end
        check("R6 back to even frame", 64'(com_lv[1:0]), 64'd3);
    endtask

    // R2
    task automatic t_unmapped();
        wr(2'd1, 4'd3,  4'b1111);
        wr(2'd2, 4'd12, 4'b1111);
        wr(2'd2, 4'd15, 4'b1111);
        wr(2'd0, 4'd7,  4'b1111);
        check_pins("R2 unmapped writes ignored");
        for (int k = 0; k < 4; k++) begin
            tick();
            check_pins($sformatf("R2 unmapped scan%0d", k));
        end
    endtask

    // R3 R5
    task automatic t_scan3_2();
        wr(2'd3, 4'd0, 4'b0000);
        wr(2'd3, 4'd0, 4'b0110);
        check_pins("R3 duty3 phase0");
        for (int k = 0; k < 6; k++) begin
            tick();
            check_pins($sformatf("R3 duty3 step%0d", k));
        end
        wr(2'd3, 4'd0, 4'b0000);
        wr(2'd3, 4'd0, 4'b0101);
        check_pins("R3 R5 duty2 half bias phase0");
        for (int k = 0; k < 4; k++) begin
            tick();
            check_pins($sformatf("R5 duty2 half bias step%0d", k));
        end
    endtask

    // R10
    task automatic t_prescale();
        wr(2'd3, 4'd0, 4'b0000);
        phase_div = 8'd2;
        wr(2'd3, 4'd0, 4'b0111);
        tick();
        tick();
        check_pins("R10 two ticks hold phase0");
        check("R10 common0 still selected", 64'(com_lv[1:0]), 64'd3);
        tick();
        check_pins("R10 third tick advances");
        check("R10 common1 selected", 64'(com_lv[3:2]), 64'd3);
        phase_div = 8'd0;
    endtask

    // R7 R8 R11
    task automatic t_blank();
        wr(2'd3, 4'd0, 4'b0100);
        check_pins("R7 duty 00 blanks");
        wr(2'd3, 4'd0, 4'b1111);
        check("R11 ladder_lo_r set", 64'(ladder_lo_r), 64'd1);
        tick();
        @(negedge clk);
        bkup = 1'b1;
        ph = 0; pol = 0; bcnt = 0;
        settle();
        check_pins("R7 bkup blanks");
        tick();
        check_pins("R7 ticks ignored in bkup");
        @(negedge clk);
        bkup = 1'b0;
        settle();
        check_pins("R8 R7 resume phase0 with kept store");
        check("R8 ladder_lo_r kept", 64'(ladder_lo_r), 64'd1);
        wr(2'd3, 4'd0, 4'b1011);
        check_pins("R7 display enable off blanks");
        wr(2'd3, 4'd0, 4'b0111);
    endtask

    // R9
    task automatic t_supply();
        wr(2'd3, 4'd1, 4'b1010);
        check_pins("R9 seg0 and seg2 supply, seg1 scanned");
        check("R9 sup_pin", 64'(sup_pin), 64'b101);
        check("R11 ladder_off follows bit0", 64'(ladder_off), 64'd0);
        tick();
        check_pins("R9 supply pins stay fixed while scanning");
        wr(2'd3, 4'd1, 4'b0101);
        check_pins("R9 seg1 supply only");
        check("R11 ladder_off set", 64'(ladder_off), 64'd1);
    endtask

    initial begin
        for (int j = 0; j < NSEG; j++) bram[j] = 4'b0000;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        t_scan4();
        t_unmapped();
        t_scan3_2();
        t_prescale();
        t_blank();
        t_supply();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule